// File: doc/BRIEF.md
# Keyed Watchdog Timer with Interrupt-Then-Reset Response

The block is a bus-attached watchdog. Software sets a timeout index, optionally picks an interrupt-first response, and sets an enable bit. From then on a down-counter runs. Software must write a fixed key value to a restart location before the counter reaches zero. If it does not, the block either asserts a system reset at once or first raises an interrupt and grants one more period. Once the enable bit is set, only the block reset can clear it.

Periods are powers of two. An index `i` selects a reload of 2^(BASE_EXP+i) - 1, which gives 2^(BASE_EXP+i) counted cycles per period. BASE_EXP defaults to 16. A separate start-up index sets the first period after enabling. The live count can be read so that software can work out the remaining time.

The response logic is a four-state machine:
- OFF: the counter tracks the start-up reload.
- RUN: the counter runs with no interrupt pending.
- IRQ: the first expiry in interrupt mode has happened and a second period is running.
- HALT: system reset is asserted.

The transitions are:
- OFF to RUN when the enable bit is set.
- RUN to RUN on a valid kick.
- RUN to IRQ on expiry in interrupt mode.
- RUN to HALT on expiry in direct mode.
- IRQ to RUN on a valid kick.
- IRQ to HALT on expiry.
- HALT has no exit except the block reset.

Top module: `wdt_timer`

## Requirements
- R1: After reset the block is disabled, direct mode is selected, both indices are 0, the count is 2^BASE_EXP - 1, and irq and sys_rst are low.
- R2: Register decode uses byte addresses. 0x0 is control: bit0 enable, bit1 mode (1 = interrupt first). 0x4 is range: bits [3:0] run index, bits [7:4] start-up index. 0x8 is the read-only count. 0xC is the write-only restart location and reads 0. Unused bits read 0, and writes to 0x8 change nothing.
- R3: While running, the count falls by exactly one each cycle from its reload value 2^(BASE_EXP+index) - 1.
- R4: While disabled, the count equals 2^(BASE_EXP+start-up index) - 1, and the first period after enabling uses that value.
- R5: A control write of 0 to bit0 does not clear a set enable bit.
- R6: Writing exactly 0x76 to 0xC while running reloads the count from the run index. Any other value, or any kick while disabled, leaves the count untouched.
- R7: In direct mode, the edge that sees a count of 0 while running raises sys_rst. That is 2^(BASE_EXP+start-up index) + 1 cycles after the enabling write.
- R8: In interrupt mode, the first expiry raises irq and reloads from the run index. A second expiry with no kick raises sys_rst and drops irq. irq and sys_rst are never high together.
- R9: A valid kick while irq is high clears irq and returns the block to RUN.
- R10: Once sys_rst is high it stays high, with the count held at 0, until the block reset. Kicks have no effect in this state.
- R11: A change to the run index while running does not alter the current count. It takes effect at the next reload.
- R12: A valid kick in the same cycle as an expiry wins. The count reloads and neither irq nor sys_rst rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational, 0 when not reading |
| wdt_irq | output | 1 | Interrupt pending after the first expiry in interrupt mode |
| wdt_sys_rst | output | 1 | System reset request, held until block reset |

## Verification
The hardest case to reach from the ports is a valid kick landing in the exact cycle where the count is zero. That cycle decides between a reload and a reset or interrupt, and random kicks almost never hit it. The bench keeps its own cycle model of the count and waits on that model until it reads zero. It then drives the key write immediately, so the write is sampled at the expiry edge. The second expiry in interrupt mode is reached in the same way, by holding off kicks for two full periods. A reduced BASE_EXP makes both periods short.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_IRQ  = 2'd2,
        ST_HALT = 2'd3
    } wdt_state_e;

    localparam logic [7:0]  OFS_CTRL  = 8'h00;
    localparam logic [7:0]  OFS_RANGE = 8'h04;
    localparam logic [7:0]  OFS_COUNT = 8'h08;
    localparam logic [7:0]  OFS_KICK  = 8'h0C;

    localparam logic [31:0] KICK_KEY  = 32'h0000_0076;

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     cnt,
    output logic [DW-1:0]     bus_rdata,
    output logic              en,
    output logic              mode,
    output logic [IDX_W-1:0]  run_idx,
    output logic [IDX_W-1:0]  init_idx,
    output logic              kick
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(OFS_RANGE);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
    localparam logic [DW-1:0]     KEY     = DW'(KICK_KEY);

    logic wr;
    logic rd;
    logic hit_ctrl;
    logic hit_range;

    assign wr        = bus_sel && bus_we;
    assign rd        = bus_sel && !bus_we;
    assign hit_ctrl  = wr && (bus_addr == A_CTRL);
    assign hit_range = wr && (bus_addr == A_RANGE);
    assign kick      = wr && (bus_addr == A_KICK) && (bus_wdata == KEY);

    // enable only ever ORs in new ones: it is sticky until block reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= 1'b0;
            mode     <= 1'b0;
            run_idx  <= '0;
            init_idx <= '0;
        end else begin
            if (hit_ctrl) begin
                en   <= en | bus_wdata[0];
                mode <= bus_wdata[1];
            end
            if (hit_range) begin
                run_idx  <= bus_wdata[IDX_W-1:0];
                init_idx <= bus_wdata[2*IDX_W-1:IDX_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                A_CTRL: begin
                    bus_rdata[0] = en;
                    bus_rdata[1] = mode;
                end
                A_RANGE: begin
                    bus_rdata[IDX_W-1:0]       = run_idx;
                    bus_rdata[2*IDX_W-1:IDX_W] = init_idx;
                end
                A_COUNT: bus_rdata = cnt;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
    parameter int CW       = 32,
    parameter int IDX_W    = 4,
    parameter int BASE_EXP = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_init,
    input  logic             load_run,
    input  logic             dec,
    input  logic [IDX_W-1:0] init_idx,
    input  logic [IDX_W-1:0] run_idx,
    output logic [CW-1:0]    cnt,
    output logic             cnt_zero
);

    localparam int           NUM_IDX = 1 << IDX_W;
    localparam logic [CW-1:0] RST_VAL = (CW'(1) << BASE_EXP) - CW'(1);

    logic [CW-1:0] reload_tbl [NUM_IDX];

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_reload
        assign reload_tbl[g] = (CW'(1) << (BASE_EXP + g)) - CW'(1);
    end

    logic [CW-1:0] init_val;
    logic [CW-1:0] run_val;

    assign init_val = reload_tbl[init_idx];
    assign run_val  = reload_tbl[run_idx];
    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= RST_VAL;
        end else if (load_init) begin
            cnt <= init_val;
        end else if (load_run) begin
            cnt <= run_val;
        end else if (dec) begin
            cnt <= cnt - CW'(1);
        end
    end

endmodule

// File: rtl/wdt_resp_fsm.sv
module wdt_resp_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       mode,
    input  logic       kick,
    input  logic       cnt_zero,
    output wdt_state_e state,
    output logic       load_init,
    output logic       load_run,
    output logic       dec,
    output logic       irq,
    output logic       sys_rst
);

    wdt_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (en) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (kick)          state_nxt = ST_RUN;
                else if (cnt_zero) state_nxt = mode ? ST_IRQ : ST_HALT;
            end
            ST_IRQ: begin
                if (kick)          state_nxt = ST_RUN;
                else if (cnt_zero) state_nxt = ST_HALT;
            end
            ST_HALT: state_nxt = ST_HALT;
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // counter steering and the two response outputs
    always_comb begin
        load_init = 1'b0;
        load_run  = 1'b0;
        dec       = 1'b0;
        irq       = 1'b0;
        sys_rst   = 1'b0;
        unique case (state)
            ST_OFF: load_init = 1'b1;
            ST_RUN: begin
                load_run = kick || (cnt_zero && mode);
                dec      = !kick && !cnt_zero;
            end
            ST_IRQ: begin
                irq      = 1'b1;
                load_run = kick;
                dec      = !kick && !cnt_zero;
            end
            ST_HALT: sys_rst = 1'b1;
            default: load_init = 1'b1;
        endcase
    end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int DW       = 32,
    parameter int ADDR_W   = 4,
    parameter int IDX_W    = 4,
    parameter int BASE_EXP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_sys_rst
);

    localparam int CW = DW;

    logic             en;
    logic             mode;
    logic [IDX_W-1:0] run_idx;
    logic [IDX_W-1:0] init_idx;
    logic             kick;
    logic [CW-1:0]    cnt;
    logic             cnt_zero;
    logic             load_init;
    logic             load_run;
    logic             dec;
    wdt_state_e       state;

    wdt_regfile #(
        .DW     (DW),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .bus_rdata (bus_rdata),
        .en        (en),
        .mode      (mode),
        .run_idx   (run_idx),
        .init_idx  (init_idx),
        .kick      (kick)
    );

    wdt_downcount #(
        .CW       (CW),
        .IDX_W    (IDX_W),
        .BASE_EXP (BASE_EXP)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_init (load_init),
        .load_run  (load_run),
        .dec       (dec),
        .init_idx  (init_idx),
        .run_idx   (run_idx),
        .cnt       (cnt),
        .cnt_zero  (cnt_zero)
    );

    wdt_resp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .mode      (mode),
        .kick      (kick),
        .cnt_zero  (cnt_zero),
        .state     (state),
        .load_init (load_init),
        .load_run  (load_run),
        .dec       (dec),
        .irq       (wdt_irq),
        .sys_rst   (wdt_sys_rst)
    );

endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk
    import wdt_pkg::*;
#(
    parameter int DW       = 32,
    parameter int ADDR_W   = 4,
    parameter int IDX_W    = 4,
    parameter int BASE_EXP = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              en,
    input logic [IDX_W-1:0]  run_idx,
    input logic [DW-1:0]     cnt,
    input wdt_state_e        state,
    input logic              irq,
    input logic              sys_rst
);

    logic key_wr;
    logic live;

    assign key_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_KICK))
                    && (bus_wdata == DW'(KICK_KEY));
    assign live   = (state == ST_RUN) || (state == ST_IRQ);

    assert_en_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);

    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (state == ST_OFF) && !irq && !sys_rst);

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !key_wr && cnt != '0) |=> cnt == $past(cnt) - DW'(1));

    assert_kick_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && key_wr) |=> cnt == ((DW'(1) << (BASE_EXP + $past(run_idx))) - DW'(1)));

    assert_direct_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cnt == '0 && !key_wr && !$past(1'b0)) |=> (sys_rst || irq));

    assert_excl_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && sys_rst));

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> sys_rst && cnt == '0);

endmodule

bind wdt_timer wdt_timer_chk #(
    .DW       (DW),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .BASE_EXP (BASE_EXP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en        (en),
    .run_idx   (run_idx),
    .cnt       (cnt),
    .state     (state),
    .irq       (wdt_irq),
    .sys_rst   (wdt_sys_rst)
);

// File: tb/sim_wdt_timer.sv
module sim_wdt_timer;

    localparam int BASE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq;
    logic        wdt_sys_rst;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    wdt_timer #(.BASE_EXP(BASE)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_irq     (wdt_irq),
        .wdt_sys_rst (wdt_sys_rst)
    );

    // ---------------- reference model from the requirements ----------------
    // phase: 0 off, 1 run, 2 irq pending, 3 reset asserted
    logic        m_en, m_mode;
    logic [3:0]  m_idx, m_init;
    logic [31:0] m_cnt;
    int          m_phase;

    function automatic logic [31:0] pval(input int i);
        return (32'd1 << (BASE + i)) - 32'd1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'h0:    return {30'd0, m_mode, m_en};
            4'h4:    return {24'd0, m_init, m_idx};
            4'h8:    return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 1'b0; m_mode <= 1'b0; m_idx <= '0; m_init <= '0;
            m_cnt <= pval(0); m_phase <= 0;
        end else begin
            automatic bit wr = bus_sel && bus_we;
            automatic bit k  = wr && bus_addr == 4'hC && bus_wdata == 32'h76;
            if (wr && bus_addr == 4'h0) begin
                m_en   <= m_en | bus_wdata[0];
                m_mode <= bus_wdata[1];
            end
            if (wr && bus_addr == 4'h4) begin
                m_idx  <= bus_wdata[3:0];
                m_init <= bus_wdata[7:4];
            end
            case (m_phase)
                0: begin
                    m_cnt <= pval(int'(m_init));
                    if (m_en) m_phase <= 1;
                end
                1, 2: begin
                    if (k) begin
                        m_cnt <= pval(int'(m_idx)); m_phase <= 1;
                    end else if (m_cnt == 0) begin
                        if (m_phase == 1 && m_mode) begin
                            m_phase <= 2; m_cnt <= pval(int'(m_idx));
                        end else begin
                            m_phase <= 3;
                        end
                    end else begin
                        m_cnt <= m_cnt - 32'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // outputs compared every cycle against the model (R7 R8 R9 R10)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(wdt_irq == (m_phase == 2), "R8 irq vs model", 32'(wdt_irq),
                32'(m_phase == 2));
            chk(wdt_sys_rst == (m_phase == 3), "R7 sys_rst vs model",
                32'(wdt_sys_rst), 32'(m_phase == 3));
        end
    end

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
            finish_run();
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        e = exp_read(a);
        chk(bus_rdata == e, tag, bus_rdata, e);
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic count_until(input bit want_rst, output int k);
        k = 0;
        while ((want_rst ? wdt_sys_rst : wdt_irq) != 1'b1 && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        int k;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 / R2: reset state and decode
        chk(wdt_irq == 0 && wdt_sys_rst == 0, "R1 outputs low after reset",
            {30'd0, wdt_sys_rst, wdt_irq}, 32'd0);
        rd_chk(4'h0, "R1 control reset value");
        rd_chk(4'h4, "R1 range reset value");
        rd_chk(4'h8, "R1 count reset value");
        chk(exp_read(4'h8) == 32'd7, "R1 count reset 2^BASE-1", exp_read(4'h8), 32'd7);
        rd_chk(4'hC, "R2 restart reads zero");
        wr_reg(4'h8, 32'h1234_5678);
        rd_chk(4'h8, "R2 count not writable");
        wr_reg(4'h4, 32'hFFFF_FFA5);
        rd_chk(4'h4, "R2 range upper bits read zero");
        rd_chk(4'h8, "R4 disabled count follows start-up index");
        chk(exp_read(4'h8) == pval(10), "R4 start-up reload value", exp_read(4'h8), pval(10));
        wr_reg(4'h4, 32'h21);
        wr_reg(4'hC, 32'h76);
        rd_chk(4'h8, "R6 kick while disabled ignored");

        // R4 R5 R6 R11 R3: enable direct mode and probe
        wr_reg(4'h0, 32'h1);
        rd_chk(4'h8, "R4 first period from start-up index");
        wr_reg(4'h0, 32'h0);
        rd_chk(4'h0, "R5 enable stays set");
        wr_reg(4'hC, 32'h77);
        rd_chk(4'h8, "R6 wrong key ignored");
        wr_reg(4'hC, 32'h76);
        rd_chk(4'h8, "R6 key reloads run period");
        wr_reg(4'h4, 32'h23);
        rd_chk(4'h8, "R11 index change leaves count");
        rd_chk(4'h8, "R3 count falls by one");
        wr_reg(4'hC, 32'h76);
        rd_chk(4'h8, "R11 new index at next reload");
        count_until(1'b1, k);
        rd_chk(4'h8, "R10 count held at zero");
        repeat (20) @(negedge clk);
        wr_reg(4'hC, 32'h76);
        chk(wdt_sys_rst == 1'b1, "R10 reset held after kick", 32'(wdt_sys_rst), 32'd1);

        // R7: exact direct-mode latency
        do_reset();
        wr_reg(4'h4, 32'h10);
        wr_reg(4'h0, 32'h1);
        count_until(1'b1, k);
        chk(k == int'(pval(1)) + 2, "R7 direct expiry latency", 32'(k), pval(1) + 2);

        // R8: interrupt then reset
        do_reset();
        wr_reg(4'h4, 32'h01);
        wr_reg(4'h0, 32'h3);
        count_until(1'b0, k);
        chk(k == int'(pval(0)) + 2, "R8 first expiry raises irq", 32'(k), pval(0) + 2);
        count_until(1'b1, k);
        chk(k == int'(pval(1)) + 1, "R8 second expiry latency", 32'(k), pval(1) + 1);
        chk(wdt_irq == 1'b0, "R8 irq drops with reset", 32'(wdt_irq), 32'd0);

        // R9: kick clears irq
        do_reset();
        wr_reg(4'h4, 32'h00);
        wr_reg(4'h0, 32'h3);
        count_until(1'b0, k);
        wr_reg(4'hC, 32'h76);
        chk(wdt_irq == 1'b0, "R9 kick clears irq", 32'(wdt_irq), 32'd0);
        rd_chk(4'h8, "R9 count after kick");

        // R12: kick in the expiry cycle
        do_reset();
        wr_reg(4'h4, 32'h00);
        wr_reg(4'h0, 32'h1);
        do @(negedge clk); while (!(m_phase == 1 && m_cnt == 0));
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h76;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        chk(wdt_sys_rst == 0 && wdt_irq == 0, "R12 kick beats expiry",
            {30'd0, wdt_sys_rst, wdt_irq}, 32'd0);
        rd_chk(4'h8, "R12 count after collision");
        chk(exp_read(4'h8) == pval(0) - 1, "R12 reload then one step",
            exp_read(4'h8), pval(0) - 1);

        // random episodes against the model
        for (int ep = 0; ep < 30; ep++) begin
            int post;
            do_reset();
            wr_reg(4'h4, {24'd0, 2'b00, 2'($urandom), 2'b00, 2'($urandom)});
            wr_reg(4'h0, {30'd0, 1'($urandom), 1'b1});
            post = 0;
            for (int c = 0; c < 600 && post < 5; c++) begin
                int r = $urandom % 10;
                if (m_phase == 3) post++;
                if (r < 3)       wr_reg(4'hC, 32'h76);
                else if (r == 3) wr_reg(4'hC, $urandom | 32'h100);
                else if (r == 4) wr_reg(4'h4, {24'd0, 2'b00, 2'($urandom), 2'b00, 2'($urandom)});
                else if (r == 5) wr_reg(4'h0, 32'($urandom % 4));
                else if (r < 8)  rd_chk(4'(($urandom % 4) * 4), "R2 R3 random readback");
                else             repeat ($urandom % 12) @(negedge clk);
            end
        end

        finish_run();
    end

endmodule